// File: doc/BRIEF.md
# Gated 16-bit event counter with prescaler

This block counts rising edges of an external count input in a 16-bit register pair. The count path runs through a divide-by-1/2/4/8 prescaler and then a gate. When gating is enabled, one of four gate sources and a polarity bit decide, each cycle, whether a counting edge may advance the timer or whether the timer holds its value. The gate sources are an external gate pin, an overflow pulse from an 8-bit companion timer, a period-match pulse from a second companion timer, and a reserved code that forces the gate to a constant 0.

Software sees four byte-wide registers through a simple write strobe and a combinational read mux: a control byte, the low and high count bytes, and a status byte that holds a sticky overflow flag. Writing either count byte stores that byte exactly and clears the hidden prescale count. The count input is either passed through a flop synchronizer chain or taken straight from the pin. The second option models an unsynchronized counter inside one clock domain.

Software that reads the count as two bytes while the timer runs must allow for a carry from the low byte into the high byte between the two reads.

Top module: `gtmr16`

## Requirements
- R1: After reset, the control, low-count, high-count and status registers all read 0, and irq_o is 0.
- R2: Control bits [3:2] select the prescale divisor: 0 selects 1, 1 selects 2, 2 selects 4 and 3 selects 8. Starting from a cleared prescaler, the count advances once for every divisor-th qualified rising edge.
- R3: A write to address 1 (low byte) or address 2 (high byte) stores the data byte exactly into that half and drops any increment due in the same cycle. The write also clears the prescale count, so a full divisor of further edges is needed before the next increment.
- R4: Only a low-to-high transition of cnt_in_i counts. Holding the input high for many cycles advances the count once.
- R5: Control bit 1 selects the count path. With bit 1 = 1 (bypass), an input that goes high before clock edge t advances the count at edge t. With bit 1 = 0 (synchronized), it advances the count at edge t+SYNC_STAGES.
- R6: Control bit 4 enables gating. With bit 4 = 0, qualified edges always count. With bit 4 = 1, edges count only when the selected gate value equals the polarity bit (control bit 5), and otherwise the count and the prescaler hold.
- R7: Control bits [7:6] select the gate source: 0 is gate_pin_i, 1 is t8_ovf_i, 2 is prd_match_i, and 3 is a constant 0.
- R8: With control bit 0 (run) clear, neither the count nor the prescaler advances, whatever the count input and gate do.
- R9: A wrap of the count from FFFFh to 0000h sets a sticky flag, read as status bit 0 at address 3 and driven on irq_o. Writing 1 to status bit 0 clears the flag, and writing 0 to it has no effect. If a wrap and a clear fall in the same cycle, the flag is set.
- R10: rd_data_o combinationally returns the register selected by rd_addr_i: address 0 is the control byte, 1 the low count, 2 the high count, and 3 the status byte (flag in bit 0, other bits 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cnt_in_i | input | 1 | Count input; rising edges are counted |
| gate_pin_i | input | 1 | External gate level (source 0) |
| t8_ovf_i | input | 1 | Companion 8-bit timer overflow pulse (source 1) |
| prd_match_i | input | 1 | Companion timer period-match pulse (source 2) |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register write address |
| wr_data_i | input | BYTE_W | Register write data |
| rd_addr_i | input | 2 | Register read address |
| rd_data_o | output | BYTE_W | Register read data |
| irq_o | output | 1 | Overflow interrupt request (mirrors sticky flag) |

## Verification
The bench builds the timer with BYTE_W = 8 and SYNC_STAGES = 3. A synchronizer chain one stage longer than the default shows that the latency of the synchronized path follows the parameter and not a fixed two cycles, and the R5 latency check samples on both sides of edge t+3. The 8-bit byte width keeps FFFFh only a byte write away, so wraps, set-versus-clear collisions and writes that land on an increment are all hit during the randomized run.

// File: rtl/gtmr16_pkg.sv
package gtmr16_pkg;
  localparam int PSEL_W = 2;
  localparam int PS_W   = (1 << PSEL_W) - 1;

  typedef struct packed {
    logic [1:0]        gate_sel;
    logic              gate_pol;
    logic              gate_en;
    logic [PSEL_W-1:0] presc_sel;
    logic              sync_byp;
    logic              run;
  } ctrl_t;

  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_LO   = 2'd1,
    REG_HI   = 2'd2,
    REG_STAT = 2'd3
  } reg_addr_e;

  typedef enum logic [1:0] {
    GSRC_PIN  = 2'd0,
    GSRC_T8   = 2'd1,
    GSRC_PRD  = 2'd2,
    GSRC_RSVD = 2'd3
  } gate_src_e;
endpackage

// File: rtl/gtmr16_edge.sv
module gtmr16_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  input  logic bypass_i,
  output logic rise_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   sync_prev_q;
  logic                   raw_prev_q;

  for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
    if (i == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q[i] <= 1'b0;
        else         sync_q[i] <= raw_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q[i] <= 1'b0;
        else         sync_q[i] <= sync_q[i-1];
    end
  end

  // both edge detectors always track, so a mode switch sees real history
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_prev_q <= 1'b0;
      raw_prev_q  <= 1'b0;
    end else begin
      sync_prev_q <= sync_q[SYNC_STAGES-1];
      raw_prev_q  <= raw_i;
    end
  end

  assign rise_o = bypass_i ? (raw_i & ~raw_prev_q)
                           : (sync_q[SYNC_STAGES-1] & ~sync_prev_q);

  a_r4_level_once: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bypass_i && raw_i) |=> !(bypass_i && rise_o));
endmodule

// File: rtl/gtmr16_gate.sv
module gtmr16_gate
  import gtmr16_pkg::*;
(
  input  logic      gate_pin_i,
  input  logic      t8_ovf_i,
  input  logic      prd_match_i,
  input  gate_src_e sel_i,
  input  logic      en_i,
  input  logic      pol_i,
  output logic      cnt_ok_o
);
  logic gate_val;

  always_comb begin
    unique case (sel_i)
      GSRC_PIN:  gate_val = gate_pin_i;
      GSRC_T8:   gate_val = t8_ovf_i;
      GSRC_PRD:  gate_val = prd_match_i;
      default:   gate_val = 1'b0;
    endcase
  end

  // count when gate level matches polarity
  assign cnt_ok_o = !en_i || (gate_val == pol_i);
endmodule

// File: rtl/gtmr16_presc.sv
module gtmr16_presc
  import gtmr16_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              adv_i,
  input  logic [PSEL_W-1:0] sel_i,
  output logic              tick_o
);
  logic [PS_W-1:0] ps_q;
  logic [PS_W-1:0] lim;

  assign lim    = PS_W'((1 << sel_i) - 1);
  // >= keeps a shrinking divisor from stranding the count above the limit
  assign tick_o = adv_i && (ps_q >= lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ps_q <= '0;
    else if (clr_i)  ps_q <= '0;
    else if (adv_i)  ps_q <= tick_o ? '0 : ps_q + 1'b1;
  end

  a_r3_presc_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (ps_q == '0));
  a_r8_presc_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!adv_i && !clr_i) |=> $stable(ps_q));
  a_r2_div1_every: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && sel_i == '0) |-> tick_o);
endmodule

// File: rtl/gtmr16.sv
module gtmr16
  import gtmr16_pkg::*;
#(
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cnt_in_i,
  input  logic              gate_pin_i,
  input  logic              t8_ovf_i,
  input  logic              prd_match_i,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_addr_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic [1:0]        rd_addr_i,
  output logic [BYTE_W-1:0] rd_data_o,
  output logic              irq_o
);
  localparam int CNT_W  = 2 * BYTE_W;
  localparam int CTRL_W = $bits(ctrl_t);

  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] cnt_q;
  logic             ovf_q;
  reg_addr_e        wa, ra;
  logic             wr_ctrl, wr_lo, wr_hi, wr_stat, cnt_wr;
  logic             rise, cnt_ok, adv, tick, wrap;

  assign wa      = reg_addr_e'(wr_addr_i);
  assign ra      = reg_addr_e'(rd_addr_i);
  assign wr_ctrl = wr_en_i && (wa == REG_CTRL);
  assign wr_lo   = wr_en_i && (wa == REG_LO);
  assign wr_hi   = wr_en_i && (wa == REG_HI);
  assign wr_stat = wr_en_i && (wa == REG_STAT);
  assign cnt_wr  = wr_lo || wr_hi;

  gtmr16_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .raw_i    (cnt_in_i),
    .bypass_i (ctrl_q.sync_byp),
    .rise_o   (rise)
  );

  gtmr16_gate u_gate (
    .gate_pin_i  (gate_pin_i),
    .t8_ovf_i    (t8_ovf_i),
    .prd_match_i (prd_match_i),
    .sel_i       (gate_src_e'(ctrl_q.gate_sel)),
    .en_i        (ctrl_q.gate_en),
    .pol_i       (ctrl_q.gate_pol),
    .cnt_ok_o    (cnt_ok)
  );

  assign adv = ctrl_q.run && rise && cnt_ok;

  gtmr16_presc u_presc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (cnt_wr),
    .adv_i  (adv),
    .sel_i  (ctrl_q.presc_sel),
    .tick_o (tick)
  );

  assign wrap = !cnt_wr && tick && (&cnt_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ctrl_q <= '0;
    else if (wr_ctrl)  ctrl_q <= ctrl_t'(wr_data_i[CTRL_W-1:0]);
  end

  // byte write wins over increment; the increment is dropped
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (cnt_wr) begin
      if (wr_lo) cnt_q[BYTE_W-1:0]     <= wr_data_i;
      if (wr_hi) cnt_q[CNT_W-1:BYTE_W] <= wr_data_i;
    end else if (tick) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // set beats clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      ovf_q <= 1'b0;
    else if (wrap)                    ovf_q <= 1'b1;
    else if (wr_stat && wr_data_i[0]) ovf_q <= 1'b0;
  end

  always_comb begin
    unique case (ra)
      REG_CTRL: rd_data_o = BYTE_W'(ctrl_q);
      REG_LO:   rd_data_o = cnt_q[BYTE_W-1:0];
      REG_HI:   rd_data_o = cnt_q[CNT_W-1:BYTE_W];
      default:  rd_data_o = BYTE_W'(ovf_q);
    endcase
  end

  assign irq_o = ovf_q;

  a_r3_lo_exact: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_lo |=> (cnt_q[BYTE_W-1:0] == $past(wr_data_i)));
  a_r3_hi_exact: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_hi |=> (cnt_q[CNT_W-1:BYTE_W] == $past(wr_data_i)));
  a_r8_off_freeze: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_q.run && !cnt_wr) |=> $stable(cnt_q));
  a_r6_gate_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cnt_ok && !cnt_wr) |=> $stable(cnt_q));
  a_r9_wrap_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && !cnt_wr && cnt_q == '1) |=> (ovf_q && cnt_q == '0));
  a_r9_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_q && !(wr_stat && wr_data_i[0])) |=> ovf_q);
endmodule

// File: tb/gtmr16_tb.sv
module gtmr16_tb;
  localparam int BW = 8;
  localparam int S  = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cnt_in = 1'b0, gate_pin = 1'b0, t8_ovf = 1'b0, prd_match = 1'b0;
  logic          wr_en = 1'b0;
  logic [1:0]    wr_addr = '0, rd_addr = 2'd1;
  logic [BW-1:0] wr_data = '0;
  logic [BW-1:0] rd_data;
  logic          irq;

  int    checks = 0, errors = 0, cyc = 0;
  bit    done = 1'b0;
  string cur_req = "R1";

  always #4 clk = ~clk;

  gtmr16 #(.BYTE_W(BW), .SYNC_STAGES(S)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cnt_in_i(cnt_in), .gate_pin_i(gate_pin),
    .t8_ovf_i(t8_ovf), .prd_match_i(prd_match), .wr_en_i(wr_en),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data), .rd_addr_i(rd_addr),
    .rd_data_o(rd_data), .irq_o(irq)
  );

  // behavioural reference model
  logic [S:0] m_hist;
  logic [7:0] m_ctrl;
  int         m_cnt, m_ps;
  bit         m_ovf;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_hist = '0; m_ctrl = '0; m_cnt = 0; m_ps = 0; m_ovf = 0;
    end else begin
      bit e, g, ok, q, wrapped;
      int div;
      wrapped = 0;
      e = m_ctrl[1] ? (cnt_in && !m_hist[0]) : (m_hist[S-1] && !m_hist[S]);
      case (m_ctrl[7:6])
        2'd0: g = gate_pin;
        2'd1: g = t8_ovf;
        2'd2: g = prd_match;
        default: g = 0;
      endcase
      ok  = !m_ctrl[4] || (g == m_ctrl[5]);
      q   = m_ctrl[0] && e && ok;
      div = 1 << m_ctrl[3:2];
      if (wr_en && (wr_addr == 2'd1 || wr_addr == 2'd2)) begin
        if (wr_addr == 2'd1) m_cnt = (m_cnt & 32'hFF00) | int'(wr_data);
        else                 m_cnt = (m_cnt & 32'h00FF) | (int'(wr_data) << 8);
        m_ps = 0;
      end else if (q) begin
        if (m_ps + 1 >= div) begin
          m_ps = 0;
          if (m_cnt == 65535) begin m_cnt = 0; wrapped = 1; end
          else m_cnt = m_cnt + 1;
        end else m_ps = m_ps + 1;
      end
      if (wr_en && wr_addr == 2'd3 && wr_data[0]) m_ovf = 0;
      if (wrapped) m_ovf = 1;
      if (wr_en && wr_addr == 2'd0) m_ctrl = wr_data;
      m_hist = {m_hist[S-1:0], cnt_in};
    end
  end

  function automatic int m_rd(logic [1:0] a);
    case (a)
      2'd0: return int'(m_ctrl);
      2'd1: return m_cnt & 255;
      2'd2: return (m_cnt >> 8) & 255;
      default: return int'(m_ovf);
    endcase
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      chk(cur_req, int'(rd_data), m_rd(rd_addr));
      chk(cur_req, int'(irq), int'(m_ovf));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd_chk(string tag, logic [1:0] a, int exp);
    rd_addr = a;
    #2;
    chk(tag, int'(rd_data), exp);
  endtask

  task automatic pulses(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); cnt_in = 1;
      @(negedge clk); cnt_in = 0;
    end
    repeat (S + 2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    rd_chk("R1", 2'd0, 0); rd_chk("R1", 2'd1, 0);
    rd_chk("R1", 2'd2, 0); rd_chk("R1", 2'd3, 0);
    chk("R1", int'(irq), 0);

    // R8 / R3: stopped timer, exact byte writes
    cur_req = "R8";
    wr(2'd0, 8'h0A); wr(2'd1, 8'h34); wr(2'd2, 8'h12);
    rd_chk("R3", 2'd1, 8'h34); rd_chk("R3", 2'd2, 8'h12);
    pulses(5);
    rd_chk("R8", 2'd1, 8'h34); rd_chk("R8", 2'd2, 8'h12);

    // R2 divide by 4
    cur_req = "R2";
    wr(2'd0, 8'h0B); wr(2'd1, 8'h00); wr(2'd2, 8'h00);
    pulses(8);  rd_chk("R2", 2'd1, 2);
    pulses(3);  rd_chk("R2", 2'd1, 2);
    // R3 write clears prescaler (3 edges pending)
    cur_req = "R3";
    wr(2'd1, 8'h10);
    pulses(1);  rd_chk("R3", 2'd1, 8'h10);
    pulses(3);  rd_chk("R3", 2'd1, 8'h11);

    // R4 level held high counts once
    cur_req = "R4";
    wr(2'd0, 8'h03); wr(2'd1, 8'h00); wr(2'd2, 8'h00);
    @(negedge clk); cnt_in = 1;
    repeat (10) @(negedge clk);
    cnt_in = 0;
    repeat (S + 2) @(negedge clk);
    rd_chk("R4", 2'd1, 1);

    // R5 synchronized latency, then bypass latency
    cur_req = "R5";
    wr(2'd0, 8'h01);
    repeat (S + 2) @(negedge clk);
    @(negedge clk); cnt_in = 1;
    @(negedge clk); cnt_in = 0;
    repeat (S - 1) @(negedge clk);
    rd_chk("R5", 2'd1, 1);
    @(negedge clk);
    rd_chk("R5", 2'd1, 2);
    wr(2'd0, 8'h03);
    repeat (S + 2) @(negedge clk);
    @(negedge clk); cnt_in = 1;
    @(negedge clk); cnt_in = 0;
    rd_chk("R5", 2'd1, 3);
    repeat (S + 2) @(negedge clk);

    // R9 wrap, sticky flag, write-1-to-clear
    cur_req = "R9";
    wr(2'd1, 8'hFF); wr(2'd2, 8'hFF);
    pulses(1);
    rd_chk("R9", 2'd1, 0); rd_chk("R9", 2'd2, 0); rd_chk("R9", 2'd3, 1);
    chk("R9", int'(irq), 1);
    wr(2'd3, 8'h00); rd_chk("R9", 2'd3, 1);
    wr(2'd3, 8'h01); rd_chk("R9", 2'd3, 0);
    chk("R9", int'(irq), 0);

    // R6 gating with polarity
    cur_req = "R6";
    wr(2'd0, 8'h13); wr(2'd1, 8'h00);
    gate_pin = 1; pulses(3); rd_chk("R6", 2'd1, 0);
    gate_pin = 0; pulses(3); rd_chk("R6", 2'd1, 3);
    wr(2'd0, 8'h33);
    pulses(2);               rd_chk("R6", 2'd1, 3);
    gate_pin = 1; pulses(2); rd_chk("R6", 2'd1, 5);

    // R7 gate source select
    cur_req = "R7";
    t8_ovf = 1; prd_match = 1;
    wr(2'd0, 8'hF3); pulses(2); rd_chk("R7", 2'd1, 5);
    wr(2'd0, 8'hD3); pulses(2); rd_chk("R7", 2'd1, 7);
    gate_pin = 0;
    wr(2'd0, 8'h73); pulses(1); rd_chk("R7", 2'd1, 8);
    t8_ovf = 0;      pulses(1); rd_chk("R7", 2'd1, 8);
    wr(2'd0, 8'hB3); pulses(1); rd_chk("R7", 2'd1, 9);
    prd_match = 0;   pulses(1); rd_chk("R7", 2'd1, 9);

    // R10 control readback
    rd_chk("R10", 2'd0, 8'hB3);

    // randomized run compared each cycle with the model
    cur_req = "R2-R10 random";
    for (int i = 0; i < 6000; i++) begin
      @(negedge clk);
      cnt_in    = ($urandom % 3) == 0;
      gate_pin  = ($urandom % 2) == 0;
      t8_ovf    = ($urandom % 5) == 0;
      prd_match = ($urandom % 4) == 0;
      rd_addr   = 2'($urandom % 4);
      wr_en     = ($urandom % 12) == 0;
      wr_addr   = 2'($urandom % 4);
      wr_data   = 8'($urandom);
      if (wr_addr == 2'd0 && ($urandom % 4) != 0) wr_data[0] = 1'b1;
      if (wr_addr == 2'd2 && ($urandom % 2) == 0) wr_data = 8'hFF;
    end
    @(negedge clk); wr_en = 0;
    repeat (4) @(negedge clk);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule